// File: doc/BRIEF.md
# Transmit Read-Back Bit Error Checker

A serial transmitter usually hears itself: the level it puts on the line comes back through the receive pin. This block listens to that echo and flags any bit where the returned level differs from the bit the shifter sent. A single comparison is made per bit. Its position inside the bit is set by a counter clocked by a 16x oversampling tick. The counter restarts on every bit-boundary strobe from the transmitter.

A select input places the comparison either at the middle of the bit (count 9) or later in the bit (count 13). The later point gives a heavily loaded or slow line more time to settle before the read-back is judged. A mismatch produces a one-cycle error pulse and sets a sticky flag, which holds until a clear input is raised. The block only reports errors. Ending the frame is the transmitter's job.

Top module: `txbit_echo_checker`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `bit_err` and `err_sticky` are 0.
- R2: A cycle with `bit_start` high and `tx_active` high sets the bit position to 1. After that, each cycle with `os_tick` high advances the position by one, and it stops at 16. While `tx_active` is low, the position is 0 (idle).
- R3: With `late_sel` low, the comparison is made in the first cycle in which the position equals 9.
- R4: With `late_sel` high, the comparison is made in the first cycle in which the position equals 13.
- R5: When a comparison finds `tx_bit` different from `rx_line`, `bit_err` is high for exactly one cycle, in the cycle after the comparison.
- R6: A mismatch sets `err_sticky` in the same cycle as `bit_err`. The flag stays set until `err_clr` is seen high, and it reads 0 from the cycle after that. If a mismatch and `err_clr` coincide, the mismatch wins.
- R7: No comparison is made in a cycle where `check_en` is low, `tx_active` is low, or `bit_start` is high.
- R8: At most one comparison is made per bit. A level change after the sample point causes no further error in that bit.
- R9: When `rx_line` equals `tx_bit` at the sample point, no error is reported.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | One-cycle 16x oversampling tick |
| bit_start | input | 1 | Bit-boundary strobe from the transmitter |
| tx_active | input | 1 | High while a frame is being sent |
| check_en | input | 1 | Enables the read-back comparison |
| late_sel | input | 1 | 0: compare at count 9, 1: compare at count 13 |
| tx_bit | input | 1 | Bit the transmit shifter is driving |
| rx_line | input | 1 | Receive pin, already synchronous to `clk` |
| err_clr | input | 1 | Clears the sticky flag |
| bit_err | output | 1 | One-cycle pulse on a read-back mismatch |
| err_sticky | output | 1 | Held error flag |

## Verification
The properties assume three things about the inputs: `rx_line` is already synchronous, `bit_start` only arrives together with `tx_active`, and every input is low while reset is held. The bench follows these rules. It drives every input on the falling edge, raises `bit_start` only inside an active frame, and holds all inputs low through reset. Errors are injected by flipping `rx_line` over chosen ranges of bit positions. These ranges are placed on the sample point, just beside it, or after it, under both select settings.

// File: rtl/echo_chk_pkg.sv
package echo_chk_pkg;

    typedef enum logic {
        SAMPLE_MID  = 1'b0,
        SAMPLE_LATE = 1'b1
    } sample_sel_e;

    typedef struct packed {
        logic pulse;
        logic sticky;
    } err_state_t;

endpackage

// File: rtl/echo_bit_timer.sv
module echo_bit_timer #(
    parameter int OSR = 16,
    parameter int CW  = $clog2(OSR + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          os_tick,
    input  logic          bit_start,
    input  logic          tx_active,
    input  logic          cmp_fire,
    output logic [CW-1:0] cnt,
    output logic          done
);
    localparam logic [CW-1:0] FIRST = CW'(1);
    localparam logic [CW-1:0] LAST  = CW'(OSR);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          done;
    } timer_state_t;

    timer_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!tx_active) begin
            st_d.cnt  = '0;
            st_d.done = 1'b0;
        end else if (bit_start) begin
            st_d.cnt  = FIRST;
            st_d.done = 1'b0;
        end else begin
            if (os_tick && st_q.cnt != '0 && st_q.cnt < LAST) begin
                st_d.cnt = st_q.cnt + FIRST;
            end
            if (cmp_fire) begin
                st_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt  = st_q.cnt;
    assign done = st_q.done;
endmodule

// File: rtl/echo_sample_cmp.sv
module echo_sample_cmp
    import echo_chk_pkg::*;
#(
    parameter int OSR      = 16,
    parameter int MID_PT   = 9,
    parameter int LATE_PT  = 13,
    parameter int CW       = $clog2(OSR + 1)
) (
    input  logic          check_en,
    input  logic          tx_active,
    input  logic          bit_start,
    input  logic          late_sel,
    input  logic [CW-1:0] cnt,
    input  logic          done,
    input  logic          tx_bit,
    input  logic          rx_line,
    output logic          cmp_fire,
    output logic          mismatch
);
    localparam logic [CW-1:0] MID_CNT  = CW'(MID_PT);
    localparam logic [CW-1:0] LATE_CNT = CW'(LATE_PT);

    sample_sel_e   sel;
    logic [CW-1:0] target;

    always_comb begin
        sel      = sample_sel_e'(late_sel);
        target   = (sel == SAMPLE_LATE) ? LATE_CNT : MID_CNT;
        cmp_fire = check_en && tx_active && !bit_start && !done && (cnt == target);
        mismatch = cmp_fire && (tx_bit != rx_line);
    end
endmodule

// File: rtl/echo_err_flag.sv
module echo_err_flag
    import echo_chk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mismatch,
    input  logic err_clr,
    output logic pulse,
    output logic sticky
);
    err_state_t ef_d, ef_q;

    always_comb begin
        ef_d       = ef_q;
        ef_d.pulse = mismatch;
        if (mismatch) begin
            ef_d.sticky = 1'b1;
        end else if (err_clr) begin
            ef_d.sticky = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ef_q <= '0;
        end else begin
            ef_q <= ef_d;
        end
    end

    assign pulse  = ef_q.pulse;
    assign sticky = ef_q.sticky;
endmodule

// File: rtl/txbit_echo_checker.sv
module txbit_echo_checker #(
    parameter int OSR     = 16,
    parameter int MID_PT  = 9,
    parameter int LATE_PT = 13
) (
    input  logic clk,
    input  logic rst_n,
    input  logic os_tick,
    input  logic bit_start,
    input  logic tx_active,
    input  logic check_en,
    input  logic late_sel,
    input  logic tx_bit,
    input  logic rx_line,
    input  logic err_clr,
    output logic bit_err,
    output logic err_sticky
);
    localparam int CW = $clog2(OSR + 1);

    logic [CW-1:0] cnt_q;
    logic          done_q;
    logic          cmp_fire;
    logic          mismatch;

    echo_bit_timer #(.OSR(OSR), .CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .os_tick  (os_tick),
        .bit_start(bit_start),
        .tx_active(tx_active),
        .cmp_fire (cmp_fire),
        .cnt      (cnt_q),
        .done     (done_q)
    );

    echo_sample_cmp #(.OSR(OSR), .MID_PT(MID_PT), .LATE_PT(LATE_PT), .CW(CW)) u_cmp (
        .check_en (check_en),
        .tx_active(tx_active),
        .bit_start(bit_start),
        .late_sel (late_sel),
        .cnt      (cnt_q),
        .done     (done_q),
        .tx_bit   (tx_bit),
        .rx_line  (rx_line),
        .cmp_fire (cmp_fire),
        .mismatch (mismatch)
    );

    echo_err_flag u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .mismatch(mismatch),
        .err_clr (err_clr),
        .pulse   (bit_err),
        .sticky  (err_sticky)
    );
endmodule

// File: rtl/txbit_echo_props.sv
module txbit_echo_props #(
    parameter int CW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bit_start,
    input logic          tx_active,
    input logic          check_en,
    input logic          err_clr,
    input logic          bit_err,
    input logic          err_sticky,
    input logic [CW-1:0] cnt
);
    p_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(tx_active && bit_start) |-> cnt == CW'(1));

    p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(tx_active) |-> cnt == '0);

    p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bit_err |=> !bit_err);

    p_err_sets_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bit_err |-> err_sticky);

    p_flag_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(err_sticky) && !$past(err_clr) |-> err_sticky);

    p_flag_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(err_clr) && !bit_err |-> !err_sticky);

    p_quiet_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(check_en) || !$past(tx_active) || $past(bit_start) |-> !bit_err);
endmodule

bind txbit_echo_checker txbit_echo_props #(.CW(CW)) u_props (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_start (bit_start),
    .tx_active (tx_active),
    .check_en  (check_en),
    .err_clr   (err_clr),
    .bit_err   (bit_err),
    .err_sticky(err_sticky),
    .cnt       (cnt_q)
);

// File: tb/txbit_echo_checker_test.sv
module txbit_echo_checker_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic os_tick = 0, bit_start = 0, tx_active = 0, check_en = 0;
    logic late_sel = 0, tx_bit = 0, rx_line = 0, err_clr = 0;
    logic bit_err, err_sticky;

    int vectors = 0;
    int fails   = 0;
    int pulses  = 0;
    int wd      = 0;

    // reference model state
    int m_pos = 0;
    bit m_used = 0;
    bit m_err = 0;
    bit m_sticky = 0;

    always #4 clk = ~clk;

    txbit_echo_checker uut (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .bit_start(bit_start),
        .tx_active(tx_active), .check_en(check_en), .late_sel(late_sel),
        .tx_bit(tx_bit), .rx_line(rx_line), .err_clr(err_clr),
        .bit_err(bit_err), .err_sticky(err_sticky)
    );

    // behavioural reference: position in bit, compare-once, flags
    always @(posedge clk) begin
        if (!rst_n) begin
            m_pos = 0; m_used = 0; m_err = 0; m_sticky = 0;
        end else begin
            int  want;
            bit  look, bad;
            want = late_sel ? 13 : 9;
            look = check_en && tx_active && !bit_start && !m_used && (m_pos == want);
            bad  = look && (tx_bit != rx_line);
            m_err = bad;
            if (bad) m_sticky = 1;
            else if (err_clr) m_sticky = 0;
            if (!tx_active) begin
                m_pos = 0; m_used = 0;
            end else if (bit_start) begin
                m_pos = 1; m_used = 0;
            end else begin
                if (os_tick && m_pos >= 1 && m_pos < 16) m_pos++;
                if (look) m_used = 1;
            end
        end
    end

    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            fails++;
            $display("FAIL watchdog expired: actual %0d cycles, expected < 150000", wd);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    task automatic step_check();
        @(negedge clk);
        vectors++;
        if (bit_err !== m_err) begin
            fails++;
            $display("FAIL R5 bit_err: actual %b expected %b at %0t", bit_err, m_err, $time);
        end
        if (err_sticky !== m_sticky) begin
            fails++;
            $display("FAIL R6 err_sticky: actual %b expected %b at %0t", err_sticky, m_sticky, $time);
        end
        if (bit_err === 1'b1) pulses++;
    endtask

    task automatic expect_eq(string tag, int act, int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // One bit: strobe, then ticks every third cycle; rx flipped while position in [lo,hi]
    task automatic run_bit(bit tx, int lo, int hi, bit late, bit en, bit clr,
                           int stop_at, int exp_pulses, string tag);
        int phase = 0;
        bit first = 1;
        pulses = 0;
        forever begin
            step_check();
            if (!first && m_pos >= stop_at) break;
            bit_start = first;
            os_tick   = (!first && phase == 2);
            phase     = first ? 0 : (phase + 1) % 3;
            tx_active = 1; check_en = en; late_sel = late; err_clr = clr;
            tx_bit    = tx;
            rx_line   = tx ^ (!first && m_pos >= lo && m_pos <= hi);
            first     = 0;
        end
        os_tick = 0;
        rx_line = tx ^ (m_pos >= lo && m_pos <= hi);
        repeat (2) step_check();
        if (stop_at == 16) expect_eq(tag, pulses, exp_pulses);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        expect_eq("R1 bit_err in reset", int'(bit_err), 0);
        expect_eq("R1 err_sticky in reset", int'(err_sticky), 0);
        rst_n = 1;
        step_check();
        expect_eq("R1 bit_err after reset", int'(bit_err), 0);
        expect_eq("R1 err_sticky after reset", int'(err_sticky), 0);

        // R9: clean echo, both polarities and both sample points
        run_bit(1, 99, 99, 0, 1, 0, 16, 0, "R9 clean 1 mid");
        run_bit(0, 99, 99, 1, 1, 0, 16, 0, "R9 clean 0 late");
        expect_eq("R9 no flag after clean bits", int'(err_sticky), 0);

        // R3: mid sample point
        run_bit(1, 9, 9, 0, 1, 0, 16, 1, "R3 flip at 9 mid");
        expect_eq("R6 flag set after mismatch", int'(err_sticky), 1);
        run_bit(0, 10, 14, 0, 1, 0, 16, 0, "R3 flip after 9 mid");
        run_bit(0, 2, 8, 0, 1, 0, 16, 0, "R3 flip before 9 mid");
        expect_eq("R6 flag holds without clear", int'(err_sticky), 1);

        // R6: clear
        @(negedge clk); err_clr = 1; vectors++;
        step_check(); err_clr = 0;
        step_check();
        expect_eq("R6 flag cleared", int'(err_sticky), 0);

        // R4: late sample point
        run_bit(1, 13, 13, 1, 1, 0, 16, 1, "R4 flip at 13 late");
        run_bit(1, 9, 12, 1, 1, 0, 16, 0, "R4 flip at 9-12 late");
        run_bit(0, 14, 16, 1, 1, 0, 16, 0, "R4 flip after 13 late");

        // R6: clear held through a mismatch bit, set wins at the collision
        run_bit(0, 9, 9, 0, 1, 1, 16, 1, "R6 clear during mismatch");
        expect_eq("R6 cleared after held clear", int'(err_sticky), 0);

        // R7: disabled
        run_bit(1, 1, 16, 0, 0, 0, 16, 0, "R7 check_en low");
        tx_active = 0; check_en = 1;
        for (int i = 0; i < 60; i++) begin
            step_check();
            os_tick = (i % 3 == 0);
            rx_line = ~tx_bit;
        end
        expect_eq("R7 idle no flag", int'(err_sticky), 0);

        // R8: line stays wrong after sample point: still one error
        run_bit(1, 9, 16, 0, 1, 0, 16, 1, "R8 once per bit mid");
        run_bit(0, 13, 16, 1, 1, 0, 16, 1, "R8 once per bit late");

        // R2: bit cut short at position 5, new strobe restarts the count
        run_bit(1, 99, 99, 0, 1, 0, 5, 0, "R2 partial");
        run_bit(1, 9, 9, 0, 1, 0, 16, 1, "R2 restart then flip at 9");
        expect_eq("R2 position saturates", m_pos, 16);

        tx_active = 0; check_en = 0;
        repeat (4) step_check();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule